// File: doc/BRIEF.md
# Shadow-Volume Depth/Stencil Engine

This block is the fixed-function per-pixel back end used for stencil shadow volumes. It takes a stream of fragments, each with a screen position, a depth value and a facing flag, and keeps a small on-chip buffer that holds one depth entry and one stencil count per pixel. Rendering takes two passes. In the depth prepass a fragment that is nearer than the stored depth overwrites it. In the stencil counting pass depth is never written, and each fragment that is nearer than the stored depth moves that pixel's signed count up or down, according to its facing.

The fragment port has two lanes. When the color target is enabled only lane 0 is taken, which gives one fragment per clock. When it is disabled both lanes are taken, which gives two fragments per clock. A clear command sweeps the buffer one pixel per cycle and drops ready while it runs. A query port returns the stored depth and count for any pixel, together with a flag that says whether the pixel is in shadow.

Top module: `shadow_ds_engine`

## Requirements
- R1: After reset every pixel holds depth all-ones (maximum) and stencil 0, and `ready_o` is 1.
- R2: In depth mode (`mode_i`=0) an accepted fragment whose depth is strictly less than the stored depth replaces it. A fragment with equal or greater depth changes nothing. Stencil values never change in this mode.
- R3: In stencil mode (`mode_i`=1) depth values never change. A stencil value changes only for a fragment whose depth is strictly less than the stored depth.
- R4: In stencil mode a passing fragment with `frag_front_i` bit = 1 (front-facing) adds 1 to its pixel's stencil value. One with bit = 0 (back-facing) subtracts 1.
- R5: The stencil value is 8 bits and wraps modulo 256: decrementing 0 gives 255, and incrementing 255 gives 0.
- R6: The query outputs show the state of the pixel at (`qry_x_i`,`qry_y_i`) as it was in the cycle the address was presented, one clock later. `qry_shadow_o` is 1 exactly when that stencil value is nonzero (shadowed), and 0 when it is zero (lit).
- R7: With `color_en_i`=1 only lane 0 is accepted and lane 1 has no effect. With `color_en_i`=0 both lanes are accepted in the same clock. Lane i occupies bits [i*W +: W] of each packed fragment port.
- R8: When both lanes hit the same pixel in one clock, both updates are applied, lane 0 first and then lane 1 against lane 0's result.
- R9: A `clear_i` pulse seen while ready drives `ready_o` low for exactly 64 cycles (one per pixel), starting the next cycle. The clear then leaves every pixel at maximum depth and stencil 0. Fragments and further `clear_i` pulses are ignored while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = depth prepass, 1 = stencil counting |
| color_en_i | input | 1 | Color target active: single-lane rate |
| clear_i | input | 1 | Start a buffer clear |
| ready_o | output | 1 | High when fragments and clears are accepted |
| frag_valid_i | input | 2 | Per-lane fragment valid |
| frag_x_i | input | 6 | Per-lane x (3 bits per lane) |
| frag_y_i | input | 6 | Per-lane y (3 bits per lane) |
| frag_z_i | input | 32 | Per-lane depth (16 bits per lane) |
| frag_front_i | input | 2 | Per-lane facing, 1 = front |
| qry_x_i | input | 3 | Query pixel x |
| qry_y_i | input | 3 | Query pixel y |
| qry_depth_o | output | 16 | Stored depth of queried pixel |
| qry_stencil_o | output | 8 | Stencil count of queried pixel |
| qry_shadow_o | output | 1 | 1 = shadowed, 0 = lit |

## Verification
A corrupted buffer entry stays invisible until that pixel is queried. It then appears on the query outputs one clock after its address is presented, either as a wrong depth or as a lit/shadow flag that does not match the net front/back balance of the fragments sent. A wrong clear sequencer shows up directly at `ready_o` as a low window that is not 64 cycles long, or as entries left stale after it. Lane-ordering and lane-gating faults show up as a missing or doubled count on a pixel that both lanes targeted.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
    localparam int STEN_W = 8;

    typedef enum logic {
        PASS_DEPTH   = 1'b0,
        PASS_STENCIL = 1'b1
    } pass_e;

    function automatic logic [STEN_W-1:0] sten_step(input logic [STEN_W-1:0] cur,
                                                     input logic front);
        return front ? cur + 1'b1 : cur - 1'b1;
    endfunction
endpackage

// File: rtl/ssu_clear_seq.sv
module ssu_clear_seq #(
    parameter int NPIX = 64,
    localparam int IW = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    output logic          busy_o,
    output logic [IW-1:0] idx_o
);
    localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (seq_q.cnt == LAST) seq_d.busy = 1'b0;
            seq_d.cnt = seq_q.cnt + 1'b1;
        end else if (clear_i) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign idx_o  = seq_q.cnt;

    assert_clear_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.busy) |-> seq_q.cnt == '0);
    assert_clear_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt != LAST) |=> (seq_q.busy && seq_q.cnt == $past(seq_q.cnt) + 1'b1));
    assert_clear_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt == LAST) |=> !seq_q.busy);
endmodule

// File: rtl/ssu_query_port.sv
module ssu_query_port #(
    parameter int XW = 3,
    parameter int YW = 3,
    parameter int ZW = 16,
    parameter int SW = 8,
    localparam int NPIX = 1 << (XW + YW)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPIX-1:0][ZW-1:0]  depth_i,
    input  logic [NPIX-1:0][SW-1:0]  sten_i,
    input  logic [XW-1:0]            qx_i,
    input  logic [YW-1:0]            qy_i,
    output logic [ZW-1:0]            depth_o,
    output logic [SW-1:0]            sten_o,
    output logic                     shadow_o
);
    typedef struct packed {
        logic [ZW-1:0] z;
        logic [SW-1:0] s;
    } qry_t;

    qry_t qry_d, qry_q;

    always_comb begin
        qry_d.z = depth_i[{qy_i, qx_i}];
        qry_d.s = sten_i[{qy_i, qx_i}];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qry_q <= '{z: '1, s: '0};
        else        qry_q <= qry_d;
    end

    assign depth_o  = qry_q.z;
    assign sten_o   = qry_q.s;
    assign shadow_o = |qry_q.s;
endmodule

// File: rtl/shadow_ds_engine.sv
module shadow_ds_engine #(
    parameter int LANES = 2,
    parameter int XW    = 3,
    parameter int YW    = 3,
    parameter int ZW    = 16,
    localparam int SW   = ssu_pkg::STEN_W,
    localparam int NPIX = 1 << (XW + YW),
    localparam int PW   = XW + YW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_i,
    input  logic                color_en_i,
    input  logic                clear_i,
    output logic                ready_o,
    input  logic [LANES-1:0]    frag_valid_i,
    input  logic [LANES*XW-1:0] frag_x_i,
    input  logic [LANES*YW-1:0] frag_y_i,
    input  logic [LANES*ZW-1:0] frag_z_i,
    input  logic [LANES-1:0]    frag_front_i,
    input  logic [XW-1:0]       qry_x_i,
    input  logic [YW-1:0]       qry_y_i,
    output logic [ZW-1:0]       qry_depth_o,
    output logic [SW-1:0]       qry_stencil_o,
    output logic                qry_shadow_o
);
    import ssu_pkg::*;

    typedef struct packed {
        logic [NPIX-1:0][ZW-1:0] depth;
        logic [NPIX-1:0][SW-1:0] sten;
    } buf_t;

    buf_t buf_d, buf_q;

    logic          clr_busy;
    logic [PW-1:0] clr_idx;
    logic [LANES-1:0] lane_act;

    ssu_clear_seq #(.NPIX(NPIX)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .busy_o  (clr_busy),
        .idx_o   (clr_idx)
    );

    assign ready_o = !clr_busy;

    // Lane 0 is always eligible; higher lanes only at the doubled rate.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_gate
            if (g == 0) begin : g_first
                assign lane_act[g] = frag_valid_i[g] && !clr_busy;
            end else begin : g_extra
                assign lane_act[g] = frag_valid_i[g] && !clr_busy && !color_en_i;
            end
        end
    endgenerate

    always_comb begin
        logic [PW-1:0] idx;
        logic [ZW-1:0] fz;
        logic          nearer;
        buf_d = buf_q;
        idx   = '0;
        fz    = '0;
        nearer = 1'b0;
        if (clr_busy) begin
            buf_d.depth[clr_idx] = '1;
            buf_d.sten[clr_idx]  = '0;
        end else begin
            // Lanes applied in stream order so same-pixel hits chain.
            for (int i = 0; i < LANES; i++) begin
                if (lane_act[i]) begin
                    idx    = {frag_y_i[i*YW +: YW], frag_x_i[i*XW +: XW]};
                    fz     = frag_z_i[i*ZW +: ZW];
                    nearer = fz < buf_d.depth[idx];
                    if (nearer) begin
                        if (mode_i == PASS_DEPTH)
                            buf_d.depth[idx] = fz;
                        else
                            buf_d.sten[idx] = sten_step(buf_d.sten[idx], frag_front_i[i]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q.depth <= '1;
            buf_q.sten  <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    ssu_query_port #(.XW(XW), .YW(YW), .ZW(ZW), .SW(SW)) u_query (
        .clk      (clk),
        .rst_n    (rst_n),
        .depth_i  (buf_q.depth),
        .sten_i   (buf_q.sten),
        .qx_i     (qry_x_i),
        .qy_i     (qry_y_i),
        .depth_o  (qry_depth_o),
        .sten_o   (qry_stencil_o),
        .shadow_o (qry_shadow_o)
    );

    generate
        for (genvar p = 0; p < NPIX; p++) begin : g_chk
            assert_depth_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_busy && mode_i == PASS_STENCIL) |=> buf_q.depth[p] == $past(buf_q.depth[p]));
            assert_sten_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_busy && mode_i == PASS_DEPTH) |=> buf_q.sten[p] == $past(buf_q.sten[p]));
            assert_depth_nearer_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_busy && mode_i == PASS_DEPTH) |=> buf_q.depth[p] <= $past(buf_q.depth[p]));
            assert_sten_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_busy && mode_i == PASS_STENCIL) |=>
                    ((SW'(buf_q.sten[p] - $past(buf_q.sten[p])) inside
                      {SW'(0), SW'(1), SW'(2), {SW{1'b1}}, SW'({SW{1'b1}} - 1)})));
        end
    endgenerate
endmodule

// File: tb/shadow_ds_engine_bench.sv
module shadow_ds_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic        color_en_i = 1'b0;
    logic        clear_i = 1'b0;
    logic        ready_o;
    logic [1:0]  frag_valid_i = '0;
    logic [5:0]  frag_x_i = '0;
    logic [5:0]  frag_y_i = '0;
    logic [31:0] frag_z_i = '0;
    logic [1:0]  frag_front_i = '0;
    logic [2:0]  qry_x_i = '0;
    logic [2:0]  qry_y_i = '0;
    logic [15:0] qry_depth_o;
    logic [7:0]  qry_stencil_o;
    logic        qry_shadow_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    shadow_ds_engine u_shadow_ds_engine (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input logic v0, input int x0, input int y0, input int z0, input logic f0,
                        input logic v1, input int x1, input int y1, input int z1, input logic f1);
        @(negedge clk);
        frag_valid_i = {v1, v0};
        frag_x_i     = {3'(x1), 3'(x0)};
        frag_y_i     = {3'(y1), 3'(y0)};
        frag_z_i     = {16'(z1), 16'(z0)};
        frag_front_i = {f1, f0};
        @(negedge clk);
        frag_valid_i = '0;
    endtask

    task automatic look(input string req, input int x, input int y,
                        input int ez, input int es);
        @(negedge clk);
        qry_x_i = 3'(x);
        qry_y_i = 3'(y);
        @(negedge clk);
        chk({req, " depth"}, int'(qry_depth_o), ez);
        chk({req, " stencil"}, int'(qry_stencil_o), es);
        chk({req, " shadow"}, int'(qry_shadow_o), int'(es != 0));
    endtask

    task automatic t_reset();
        chk("R1 ready", int'(ready_o), 1);
        look("R1 px00", 0, 0, 16'hFFFF, 0);
        look("R1 px77", 7, 7, 16'hFFFF, 0);
    endtask

    task automatic t_depth_pass();
        mode_i = 1'b0; color_en_i = 1'b0;
        fire(1, 1, 2, 100, 1, 0, 0, 0, 0, 0);
        look("R2 nearer written", 1, 2, 100, 0);
        fire(1, 1, 2, 200, 1, 0, 0, 0, 0, 0);
        look("R2 farther kept", 1, 2, 100, 0);
        fire(1, 3, 3, 50, 0, 1, 4, 4, 60, 0);
        look("R7 dual lane0", 3, 3, 50, 0);
        look("R7 dual lane1", 4, 4, 60, 0);
        fire(1, 5, 5, 70, 0, 1, 5, 5, 40, 0);
        look("R8 same px 70 then 40", 5, 5, 40, 0);
        fire(1, 6, 5, 40, 0, 1, 6, 5, 70, 0);
        look("R8 same px 40 then 70", 6, 5, 40, 0);
        color_en_i = 1'b1;
        fire(1, 2, 2, 10, 0, 1, 7, 7, 10, 0);
        look("R7 color lane0", 2, 2, 10, 0);
        look("R7 color lane1 ignored", 7, 7, 16'hFFFF, 0);
    endtask

    task automatic t_stencil_pass();
        mode_i = 1'b1; color_en_i = 1'b0;
        fire(1, 1, 2, 90, 1, 0, 0, 0, 0, 0);
        look("R3 R4 front passes, depth kept", 1, 2, 100, 1);
        fire(1, 1, 2, 150, 1, 0, 0, 0, 0, 0);
        look("R3 failing depth no count", 1, 2, 100, 1);
        fire(1, 1, 2, 100, 1, 0, 0, 0, 0, 0);
        look("R3 equal depth no count", 1, 2, 100, 1);
        fire(1, 1, 2, 50, 0, 0, 0, 0, 0, 0);
        look("R4 R6 back returns lit", 1, 2, 100, 0);
        fire(1, 0, 0, 5, 1, 1, 0, 0, 7, 1);
        look("R8 both lanes counted", 0, 0, 16'hFFFF, 2);
        color_en_i = 1'b1;
        fire(1, 3, 3, 10, 1, 1, 0, 0, 3, 0);
        look("R7 color lane0 counted", 3, 3, 50, 1);
        look("R7 color lane1 ignored", 0, 0, 16'hFFFF, 2);
    endtask

    task automatic t_wrap();
        mode_i = 1'b1; color_en_i = 1'b0;
        fire(1, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        look("R5 wrap below zero", 7, 0, 16'hFFFF, 255);
        fire(1, 7, 0, 0, 1, 1, 7, 0, 1, 1);
        look("R5 wrap above 255", 7, 0, 16'hFFFF, 1);
    endtask

    task automatic t_query_timing();
        // Query presented in the same clock as an update sees the old value.
        @(negedge clk);
        qry_x_i = 3'd3; qry_y_i = 3'd3;
        frag_valid_i = 2'b01; frag_x_i = 6'd3; frag_y_i = 6'd3;
        frag_z_i = 32'd20; frag_front_i = 2'b01;
        @(negedge clk);
        frag_valid_i = '0;
        chk("R6 old value seen", int'(qry_stencil_o), 1);
        @(negedge clk);
        chk("R6 new value next", int'(qry_stencil_o), 2);
    endtask

    task automatic t_clear();
        int low = 0;
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        while (!ready_o && low < 500) begin
            low++;
            if (low == 10) clear_i = 1'b1;
            if (low == 11) clear_i = 1'b0;
            if (low == 20) begin
                mode_i = 1'b0; frag_valid_i = 2'b01;
                frag_x_i = 6'd1; frag_y_i = 6'd1; frag_z_i = 32'd3;
            end
            if (low == 21) frag_valid_i = '0;
            @(negedge clk);
        end
        chk("R9 ready low cycles", low, 64);
        look("R9 cleared px12", 1, 2, 16'hFFFF, 0);
        look("R9 cleared px00", 0, 0, 16'hFFFF, 0);
        look("R9 fragment during clear ignored", 1, 1, 16'hFFFF, 0);
        chk("R9 ready back", int'(ready_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_depth_pass();
        t_stencil_pass();
        t_wrap();
        t_query_timing();
        t_clear();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule